// File: doc/BRIEF.md
# Tree Pseudo-LRU Victim Selector

This block holds approximate recency state for every set of a set-associative cache and names the way to evict when a fill arrives. Each set keeps one binary decision tree of WAYS-1 bits. Every hit or fill reported on the access port turns the bits along the touched way's path so that they point at the other half. A later fill request on a full set then follows the bits from the root down to a leaf, and that leaf is the victim.

When the addressed set still has an empty line, that line is used and the tree is ignored. The lowest-numbered invalid way is chosen. The answer is registered and appears one cycle after the request. With WAYS set to 2, the tree is a single bit per set and gives exact LRU.

All pins are plain strobes with no back-pressure. A fill request is always answered on the next cycle, and an access report is always absorbed in the cycle it is presented. One set index serves both the access report and the lookup in a given cycle.

Top module: `plru_victim_sel`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears every tree bit of every set, so the first full-set victim of every set is way 0, and victim_valid is low after reset.
- R2: victim_valid is high in exactly the cycle after a cycle with fill_req high. victim_way is meaningful only while victim_valid is high.
- R3: If line_valid has any zero bit when fill_req is sampled, victim_way is the lowest index whose line_valid bit is zero, whatever the tree state.
- R4: On a full set the victim is found by walking the tree. The root is node 0. A node bit of 0 selects the lower-numbered half of its ways and 1 selects the upper half. The children of node i are node 2i+1 for the lower half and node 2i+2 for the upper half, and the leaves are the ways in order. After reset and a single access to way w, the victim is way 4 if w is below 4, and way 0 otherwise.
- R5: When acc_valid is high, each tree bit on the path to acc_way in set req_set is written so that it points at the subtree not containing acc_way. All other bits keep their values.
- R6: An access to one set leaves the victim choice of every other set unchanged.
- R7: When acc_valid and fill_req are high in the same cycle, the lookup uses the tree state from before that cycle's update.
- R8: With WAYS=2, the full-set victim is the way other than the one most recently accessed in that set, or way 0 if the set has had no access since reset.
- R9: If a set is accessed on way w, and the next cycle is a fill request on the same full set with no access, the victim is not w.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_set | input | SET_W | Set addressed by this cycle's access and fill request |
| acc_valid | input | 1 | A hit or a completed fill occurred on acc_way |
| acc_way | input | WAY_W | Way that was hit or filled |
| fill_req | input | 1 | Request for a victim in req_set |
| line_valid | input | WAYS | Valid bit of each way of req_set |
| victim_valid | output | 1 | victim_way holds an answer (one cycle after fill_req) |
| victim_way | output | WAY_W | Chosen way |

## Verification
The checker watches every cycle for three things. It checks the one-cycle answer timing. It checks that a victim chosen from a set with a free line is the lowest free way. It checks that a full-set victim never names the way touched in the cycle just before on that set. The exact tree walk, the path updates, the independence of sets, the old-state rule for a same-cycle access and fill, and exact LRU in 2-way mode need a bench model of the recency state. They are shown only by the bench's sweeps over all single accesses and all 256 valid patterns, and by long pseudo-random access and fill sequences in both the 8-way and 2-way configurations.

// File: rtl/plru_pkg.sv
package plru_pkg;
  // Heap index of the tree node visited at level lvl on the way to leaf way.
  function automatic int unsigned path_node(int unsigned lvl, int unsigned way,
                                            int unsigned levels);
    return ((32'd1 << lvl) - 32'd1) + (way >> (levels - lvl));
  endfunction

  // Direction bit of leaf way at level lvl (1 = upper half).
  function automatic logic path_dir(int unsigned lvl, int unsigned way,
                                    int unsigned levels);
    return logic'((way >> (levels - 1 - lvl)) & 32'd1);
  endfunction
endpackage

// File: rtl/plru_tree_store.sv
module plru_tree_store #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TB      = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_en,
  input  logic [SET_W-1:0] set_idx,
  input  logic [WAY_W-1:0] upd_way,
  output logic [TB-1:0]    cur_bits
);
  import plru_pkg::*;

  logic [TB-1:0] tree_q [NUM_SETS];
  logic [TB-1:0] next_bits;

  assign cur_bits = tree_q[set_idx];

  generate
    if (WAYS == 2) begin : g_pair
      always_comb next_bits = ~upd_way[0];
    end else begin : g_tree
      always_comb begin
        next_bits = tree_q[set_idx];
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
          next_bits[path_node(lvl, int'(upd_way), WAY_W)] =
            ~path_dir(lvl, int'(upd_way), WAY_W);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
    end else if (upd_en) begin
      tree_q[set_idx] <= next_bits;
    end
  end
endmodule

// File: rtl/plru_tree_walk.sv
module plru_tree_walk #(
  parameter int WAYS    = 8,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int TB     = WAYS - 1
) (
  input  logic [TB-1:0]    bits,
  output logic [WAY_W-1:0] leaf_way
);
  generate
    if (WAYS == 2) begin : g_pair
      assign leaf_way = bits[0];
    end else begin : g_tree
      always_comb begin
        int node;
        node = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
          node = 2 * node + 1 + int'(bits[node]);
        end
        leaf_way = WAY_W'(node - TB);
      end
    end
  endgenerate
endmodule

// File: rtl/plru_free_pick.sv
module plru_free_pick #(
  parameter int WAYS   = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  line_valid,
  output logic             any_free,
  output logic [WAY_W-1:0] free_way
);
  always_comb begin
    free_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!line_valid[i]) free_way = WAY_W'(i);
    end
  end
  assign any_free = ~&line_valid;
endmodule

// File: rtl/plru_victim_sel.sv
module plru_victim_sel #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(WAYS),
  localparam int TB      = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] req_set,
  input  logic             acc_valid,
  input  logic [WAY_W-1:0] acc_way,
  input  logic             fill_req,
  input  logic [WAYS-1:0]  line_valid,
  output logic             victim_valid,
  output logic [WAY_W-1:0] victim_way
);
  logic [TB-1:0]    set_bits;
  logic [WAY_W-1:0] tree_way;
  logic [WAY_W-1:0] free_way;
  logic             any_free;

  plru_tree_store #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_store (
    .clk(clk), .rst(rst), .upd_en(acc_valid), .set_idx(req_set),
    .upd_way(acc_way), .cur_bits(set_bits)
  );

  plru_tree_walk #(.WAYS(WAYS)) u_walk (.bits(set_bits), .leaf_way(tree_way));

  plru_free_pick #(.WAYS(WAYS)) u_free (
    .line_valid(line_valid), .any_free(any_free), .free_way(free_way)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      victim_valid <= 1'b0;
      victim_way   <= '0;
    end else begin
      victim_valid <= fill_req;
      if (fill_req) victim_way <= any_free ? free_way : tree_way;
    end
  end
endmodule

// File: rtl/plru_victim_chk.sv
module plru_victim_chk #(
  parameter int NUM_SETS = 16,
  parameter int WAYS     = 8,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int WAY_W   = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst,
  input logic [SET_W-1:0] req_set,
  input logic             acc_valid,
  input logic [WAY_W-1:0] acc_way,
  input logic             fill_req,
  input logic [WAYS-1:0]  line_valid,
  input logic             victim_valid,
  input logic [WAY_W-1:0] victim_way
);
  logic [WAYS-1:0]  lv_q;
  logic             last_acc;
  logic [SET_W-1:0] last_set;
  logic [WAY_W-1:0] last_way;
  logic             guard_q;
  logic [WAY_W-1:0] guard_way;
  logic [WAYS-1:0]  lowmask;

  always_ff @(posedge clk) begin
    if (rst) begin
      lv_q <= '1; last_acc <= 1'b0; last_set <= '0; last_way <= '0;
      guard_q <= 1'b0; guard_way <= '0;
    end else begin
      if (fill_req) lv_q <= line_valid;
      last_acc <= acc_valid;
      last_set <= req_set;
      last_way <= acc_way;
      guard_q  <= fill_req && (&line_valid) && !acc_valid && last_acc &&
                  (last_set == req_set);
      guard_way <= last_way;
    end
  end

  assign lowmask = (WAYS'(1) << victim_way) - WAYS'(1);

  // R2
  answer_follows_chk: assert property (@(posedge clk) disable iff (rst)
    fill_req |=> victim_valid);
  // R2
  no_spurious_answer_chk: assert property (@(posedge clk) disable iff (rst)
    !fill_req |=> !victim_valid);
  // R3
  free_way_is_free_chk: assert property (@(posedge clk) disable iff (rst)
    (victim_valid && !(&lv_q)) |-> !lv_q[victim_way]);
  // R3
  free_way_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    (victim_valid && !(&lv_q)) |-> ((lv_q & lowmask) == lowmask));
  // R9
  recent_not_victim_chk: assert property (@(posedge clk) disable iff (rst)
    guard_q |-> (victim_way != guard_way));
endmodule

bind plru_victim_sel plru_victim_chk #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_chk (.*);

// File: tb/sim_plru_victim_sel.sv
module sim_plru_victim_sel;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic [1:0] req_set = '0;
  logic       acc_valid = 0;
  logic [2:0] acc_way = '0;
  logic       fill_req = 0;
  logic [7:0] line_valid = '1;
  logic       victim_valid;
  logic [2:0] victim_way;

  logic [1:0] b_set = '0;
  logic       b_acc = 0;
  logic       b_way = 0;
  logic       b_fill = 0;
  logic [1:0] b_lv = '1;
  logic       b_vv;
  logic       b_vw;

  plru_victim_sel #(.NUM_SETS(4), .WAYS(8)) u0 (
    .clk(clk), .rst(rst), .req_set(req_set), .acc_valid(acc_valid),
    .acc_way(acc_way), .fill_req(fill_req), .line_valid(line_valid),
    .victim_valid(victim_valid), .victim_way(victim_way)
  );

  plru_victim_sel #(.NUM_SETS(4), .WAYS(2)) u1 (
    .clk(clk), .rst(rst), .req_set(b_set), .acc_valid(b_acc),
    .acc_way(b_way), .fill_req(b_fill), .line_valid(b_lv),
    .victim_valid(b_vv), .victim_way(b_vw)
  );

  int total = 0;
  int fails = 0;
  bit mb [4][3][4];
  int lastw [4];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int m_victim(int s, logic [7:0] lv);
    int lo;
    for (int i = 0; i < 8; i++) if (!lv[i]) return i;
    lo = 0;
    for (int lvl = 0; lvl < 3; lvl++)
      if (mb[s][lvl][lo >> (3 - lvl)]) lo += 8 >> (lvl + 1);
    return lo;
  endfunction

  task automatic m_access(int s, int w);
    for (int lvl = 0; lvl < 3; lvl++)
      mb[s][lvl][w >> (3 - lvl)] = !((w >> (2 - lvl)) & 1);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    acc_valid = 0; fill_req = 0; b_acc = 0; b_fill = 0;
    @(posedge clk); @(negedge clk); rst = 0;
    for (int s = 0; s < 4; s++) begin
      lastw[s] = 1;
      for (int l = 0; l < 3; l++) for (int p = 0; p < 4; p++) mb[s][l][p] = 0;
    end
  endtask

  // One cycle on the 8-way instance; checks the answer when a fill is requested.
  task automatic cyc(bit a, int w, bit f, int s, logic [7:0] lv, string req);
    int exp;
    acc_valid = a; acc_way = 3'(w); fill_req = f; req_set = 2'(s); line_valid = lv;
    exp = f ? m_victim(s, lv) : 0;
    if (a) m_access(s, w);
    @(posedge clk); @(negedge clk);
    acc_valid = 0; fill_req = 0;
    if (f) begin
      chk(victim_valid == 1'b1, {req, " valid"}, int'(victim_valid), 1);
      chk(int'(victim_way) == exp, req, int'(victim_way), exp);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state
    chk(victim_valid == 1'b0, "R1 valid low after reset", int'(victim_valid), 0);
    for (int s = 0; s < 4; s++) cyc(0, 0, 1, s, 8'hFF, "R1 first victim");

    // R2: no answer without a request
    @(posedge clk); @(negedge clk);
    chk(victim_valid == 1'b0, "R2 idle valid", int'(victim_valid), 0);

    // R4: single access from reset, every way, explicit expectation
    for (int w = 0; w < 8; w++) begin
      do_reset();
      cyc(1, w, 0, 0, 8'hFF, "R4");
      @(negedge clk); fill_req = 1; req_set = 0; line_valid = 8'hFF;
      @(posedge clk); @(negedge clk); fill_req = 0;
      chk(int'(victim_way) == ((w < 4) ? 4 : 0), "R4 single access walk",
          int'(victim_way), (w < 4) ? 4 : 0);
    end

    // R5: touch all ways in order, then walk
    do_reset();
    for (int w = 0; w < 8; w++) cyc(1, w, 0, 1, 8'hFF, "R5");
    cyc(0, 0, 1, 1, 8'hFF, "R5 after full sweep");
    chk(int'(victim_way) == 0, "R5 oldest after sweep", int'(victim_way), 0);

    // R3: all valid patterns over a non-trivial tree state
    cyc(1, 5, 0, 1, 8'hFF, "R3 prep");
    for (int p = 0; p < 256; p++) cyc(0, 0, 1, 1, 8'(p), "R3 free way");

    // R6: heavy traffic on set 2 leaves set 3 at its reset choice
    do_reset();
    for (int w = 0; w < 8; w++) cyc(1, 7 - w, 0, 2, 8'hFF, "R6");
    cyc(0, 0, 1, 3, 8'hFF, "R6 other set untouched");
    chk(int'(victim_way) == 0, "R6 set3 way", int'(victim_way), 0);

    // R7: same-cycle access and fill see the old state
    do_reset();
    cyc(1, 0, 1, 0, 8'hFF, "R7 same cycle");
    chk(int'(victim_way) == 0, "R7 old state", int'(victim_way), 0);
    cyc(0, 0, 1, 0, 8'hFF, "R7 after update");

    // R5, R9: pseudo-random mixed traffic against the model
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom);
      int w = r & 7;
      int s = (r >> 3) & 3;
      bit a = ((r >> 5) & 3) != 0;
      bit f = ((r >> 7) & 1) == 1;
      logic [7:0] lv = (((r >> 8) & 3) == 0) ? 8'(r >> 10) : 8'hFF;
      cyc(a, w, f, s, lv, "R5 random");
      if (a && !f) begin
        cyc(0, 0, 1, s, 8'hFF, "R9 recent way");
        chk(int'(victim_way) != w, "R9 not recent", int'(victim_way), w);
      end
    end

    // R8: 2-way instance is exact LRU
    do_reset();
    for (int n = 0; n < 2000; n++) begin
      int r = int'($urandom);
      int s = r & 3;
      int exp;
      b_set = 2'(s); b_lv = 2'b11;
      if ((r >> 2) & 1) begin
        b_acc = 1; b_way = 1'((r >> 3) & 1); b_fill = 0;
        lastw[s] = (r >> 3) & 1;
        @(posedge clk); @(negedge clk); b_acc = 0;
      end else begin
        b_fill = 1; exp = 1 - lastw[s];
        @(posedge clk); @(negedge clk); b_fill = 0;
        chk(b_vv == 1'b1, "R8 valid", int'(b_vv), 1);
        chk(int'(b_vw) == exp, "R8 exact LRU", int'(b_vw), exp);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule